// File: doc/BRIEF.md
# Trace Port Frame Packer

The packer sits between a processor trace port and a 32-bit trace RAM. Each clock it may receive one trace sample: a 3-bit pipeline status, a packet field and a sync flag, plus a marker saying the sample is the trigger cycle. Depending on the trace port width chosen when capture starts (4, 8 or 16 packet bits), samples are placed into fixed slots of a 32-bit word: three, two or one samples per word. When a word's last slot fills, the word is presented with a one-cycle valid strobe for the RAM writer.

Capture is opened with a start pulse, which checks the port configuration, and closed with a stop pulse. On stop, any partially filled word is emitted with its unused slots as zeros, so nothing captured is lost. An empty flag tells the controller that no partial word is held, which is the condition for declaring the capture drained.

A trigger sample carries a reserved status code in its status field; its real pipeline status is moved into the low three bits of its packet field so a decoder can recover it.

Top module: `trace_frame_packer`

## Requirements
- R1: Width code 0 (4-bit port): each slot is 8 bits laid out as status in bits 2:0, packet in bits 6:3 and sync in bit 7; slots sit at word bits 7:0, 15:8 and 23:16, three samples make a word, and word bits 31:24 are zero.
- R2: Width code 1 (8-bit port): each slot is 12 bits laid out as status in bits 2:0, packet in bits 10:3 and sync in bit 11; slots sit at word bits 11:0 and 23:12, two samples make a word, and word bits 31:24 are zero.
- R3: Width code 2 (16-bit port): one sample per word with status in bits 2:0, packet in bits 18:3 and sync in bit 19; word bits 31:20 are zero.
- R4: The first sample after a word boundary goes in the lowest slot; `word_vld` is high for exactly the one cycle after the clock edge that accepts the sample filling the last slot.
- R5: For a sample with `smp_trig` high, the slot's status field holds code 3'b110 and the low three bits of its packet field hold the sample's `smp_stat`; the remaining packet bits come from `smp_pkt`.
- R6: A start pulse while idle opens capture only for mode 0 (normal) with width code 0, 1 or 2, or mode 1 (demultiplexed) with width code 1; otherwise `cfg_err` goes high and `active` stays low. A later accepted start clears `cfg_err`. The width is latched at start; changing `cfg_width` during capture has no effect.
- R7: A stop pulse while active closes capture; a partial word is emitted the next cycle with unused slots zero; with no partial word held, no word is emitted.
- R8: A sample arriving in the same cycle as stop is packed; if it fills the word, exactly one word is emitted, otherwise the flushed word includes it.
- R9: `empty` is high exactly when no partial word is held: after reset, in the cycle a word is emitted and after a flush.
- R10: Samples presented while capture is not active are ignored: no word is emitted and `empty` stays high.
- R11: Bits of `smp_pkt` above the selected port width are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_width | input | 2 | Port width code: 0 = 4-bit, 1 = 8-bit, 2 = 16-bit, 3 = illegal |
| cfg_mode | input | 2 | Port mode: 0 = normal, 1 = demultiplexed, 2 = multiplexed, 3 = reserved |
| cap_start | input | 1 | Start pulse, honoured while idle |
| cap_stop | input | 1 | Stop pulse, honoured while active |
| smp_valid | input | 1 | A trace sample is present this cycle |
| smp_stat | input | 3 | Pipeline status of the sample |
| smp_pkt | input | 16 | Packet bits; only the low port-width bits are used |
| smp_sync | input | 1 | Sync flag of the sample |
| smp_trig | input | 1 | Sample is the trigger cycle |
| word_vld | output | 1 | One-cycle strobe: `word_data` holds a finished word |
| word_data | output | 32 | Packed word |
| empty | output | 1 | No partial word is held |
| active | output | 1 | Capture is open |
| cfg_err | output | 1 | Last start attempt was rejected |

## Verification
The stop pulse and the arrival of a sample can fall in the same cycle, including the sample that fills the last slot of a word. The bench forces this by lining stop up with the first, second and final slot of a word in each port width, and also lets random stop timing land on it during random capture runs. A bench model, built from the slot layouts, judges that exactly one word comes out carrying the late sample, and that no extra zero word follows it.

// File: rtl/trace_pack_pkg.sv
// Package: shared encodings and slot geometry for the trace frame packer.
// Assumes a 32-bit output word and a 3-bit pipeline status.
package trace_pack_pkg;

    localparam int STAT_W    = 3;
    localparam int PKT_MAX_W = 16;
    localparam int N_WIDTHS  = 3;

    typedef enum logic [1:0] {
        PW_4   = 2'd0,
        PW_8   = 2'd1,
        PW_16  = 2'd2,
        PW_BAD = 2'd3
    } port_width_e;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'd0,
        PM_DEMUX  = 2'd1,
        PM_MUX    = 2'd2,
        PM_RSVD   = 2'd3
    } port_mode_e;

    // Number of samples one word carries for a given port width.
    function automatic logic [1:0] slots_per_word(input port_width_e w);
        case (w)
            PW_4:    return 2'd3;
            PW_8:    return 2'd2;
            default: return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/trace_cfg_check.sv
// Module: trace_cfg_check
// Decides whether a port width / port mode pair may open a capture.
// Normal mode takes any legal width; demultiplexed mode takes only the
// 8-bit width; multiplexed and reserved modes are always refused.
// Purely combinational.
module trace_cfg_check
    import trace_pack_pkg::*;
(
    input  port_width_e width,
    input  port_mode_e  mode,
    output logic        cfg_ok
);

    // Legality of the requested configuration.
    always_comb begin
        case (mode)
            PM_NORMAL: cfg_ok = (width != PW_BAD);
            PM_DEMUX:  cfg_ok = (width == PW_8);
            default:   cfg_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/trace_slot_fmt.sv
// Module: trace_slot_fmt
// Formats one sample into its slot and places it at the word offset for
// the given slot index. One formatter per port width is generated; the
// latched width picks the result. Trigger samples carry TRIG_CODE in the
// status field and their real status in the low packet bits.
// Assumes slot_idx is below the slot count of the selected width.
module trace_slot_fmt
    import trace_pack_pkg::*;
#(
    parameter int               WORD_W    = 32,
    parameter logic [STAT_W-1:0] TRIG_CODE = 3'b110
) (
    input  port_width_e          width,
    input  logic [1:0]           slot_idx,
    input  logic [STAT_W-1:0]    stat,
    input  logic [PKT_MAX_W-1:0] pkt,
    input  logic                 sync,
    input  logic                 trig,
    output logic [WORD_W-1:0]    placed
);

    logic [WORD_W-1:0] placed_v [N_WIDTHS];

    for (genvar g = 0; g < N_WIDTHS; g++) begin : g_width
        localparam int PW     = 4 << g;
        localparam int SLOT_W = STAT_W + PW + 1;

        logic [PW-1:0]     pk_f;
        logic [STAT_W-1:0] st_f;
        logic [SLOT_W-1:0] slot;
        int                shamt;

        // Build the slot for this width and shift it to its offset.
        always_comb begin
            st_f  = trig ? TRIG_CODE : stat;
            pk_f  = trig ? {pkt[PW-1:STAT_W], stat} : pkt[PW-1:0];
            slot  = {sync, pk_f, st_f};
            shamt = int'(slot_idx) * SLOT_W;
            placed_v[g] = WORD_W'(slot) << shamt;
        end
    end

    // Select the formatter of the latched width.
    always_comb begin
        case (width)
            PW_4:    placed = placed_v[0];
            PW_8:    placed = placed_v[1];
            PW_16:   placed = placed_v[2];
            default: placed = '0;
        endcase
    end

endmodule

// File: rtl/trace_word_asm.sv
// Module: trace_word_asm
// Accumulates placed slots into a word. Emits the word with a one-cycle
// strobe when the last slot fills, or early on stop (unused slots stay
// zero). Assumes slots_per changes only while no partial word is held.
module trace_word_asm #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              stop,
    input  logic [WORD_W-1:0] slot_bits,
    input  logic [1:0]        slots_per,
    output logic [1:0]        slot_cnt,
    output logic              word_vld,
    output logic [WORD_W-1:0] word_data
);

    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] merged;
    logic [1:0]        cnt_inc;

    // Word as it would look with the current sample added.
    always_comb begin
        merged  = acc | slot_bits;
        cnt_inc = slot_cnt + 2'd1;
    end

    // Accumulate samples and emit on fill or on stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            slot_cnt  <= '0;
            word_vld  <= 1'b0;
            word_data <= '0;
        end else begin
            word_vld <= 1'b0;
            if (accept) begin
                if ((cnt_inc == slots_per) || stop) begin
                    word_data <= merged;
                    word_vld  <= 1'b1;
                    acc       <= '0;
                    slot_cnt  <= '0;
                end else begin
                    acc      <= merged;
                    slot_cnt <= cnt_inc;
                end
            end else if (stop && (slot_cnt != 2'd0)) begin
                word_data <= acc;
                word_vld  <= 1'b1;
                acc       <= '0;
                slot_cnt  <= '0;
            end
        end
    end

    // R4: the slot counter never reaches the fill count
    a_r4_cnt_below_fill: assert property (@(posedge clk) disable iff (!rst_n)
        slot_cnt < slots_per);

endmodule

// File: rtl/trace_frame_packer.sv
// Module: trace_frame_packer (top)
// Packs per-cycle trace samples into 32-bit trace RAM words. Capture opens
// on a start pulse with a legal configuration and closes on a stop pulse,
// which flushes a partial word. Assumes start and stop are single-cycle
// pulses from a controller in the same clock domain.
module trace_frame_packer
    import trace_pack_pkg::*;
#(
    parameter int               WORD_W    = 32,
    parameter logic [STAT_W-1:0] TRIG_CODE = 3'b110
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cfg_width,
    input  logic [1:0]           cfg_mode,
    input  logic                 cap_start,
    input  logic                 cap_stop,
    input  logic                 smp_valid,
    input  logic [STAT_W-1:0]    smp_stat,
    input  logic [PKT_MAX_W-1:0] smp_pkt,
    input  logic                 smp_sync,
    input  logic                 smp_trig,
    output logic                 word_vld,
    output logic [WORD_W-1:0]    word_data,
    output logic                 empty,
    output logic                 active,
    output logic                 cfg_err
);

    port_width_e       cur_width;
    logic              cfg_ok;
    logic              accept;
    logic              stop_now;
    logic [1:0]        slot_cnt;
    logic [1:0]        slots_per;
    logic [WORD_W-1:0] slot_bits;

    trace_cfg_check i_cfg (
        .width  (port_width_e'(cfg_width)),
        .mode   (port_mode_e'(cfg_mode)),
        .cfg_ok (cfg_ok)
    );

    // Sample acceptance and stop qualification.
    always_comb begin
        accept    = active && smp_valid;
        stop_now  = active && cap_stop;
        slots_per = slots_per_word(cur_width);
        empty     = (slot_cnt == 2'd0);
    end

    // Capture state, latched width and configuration error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            cfg_err   <= 1'b0;
            cur_width <= PW_4;
        end else if (stop_now) begin
            active <= 1'b0;
        end else if (!active && cap_start) begin
            if (cfg_ok) begin
                active    <= 1'b1;
                cfg_err   <= 1'b0;
                cur_width <= port_width_e'(cfg_width);
            end else begin
                cfg_err <= 1'b1;
            end
        end
    end

    trace_slot_fmt #(
        .WORD_W    (WORD_W),
        .TRIG_CODE (TRIG_CODE)
    ) i_fmt (
        .width    (cur_width),
        .slot_idx (slot_cnt),
        .stat     (smp_stat),
        .pkt      (smp_pkt),
        .sync     (smp_sync),
        .trig     (smp_trig),
        .placed   (slot_bits)
    );

    trace_word_asm #(
        .WORD_W (WORD_W)
    ) i_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .stop      (stop_now),
        .slot_bits (slot_bits),
        .slots_per (slots_per),
        .slot_cnt  (slot_cnt),
        .word_vld  (word_vld),
        .word_data (word_data)
    );

    // R9: an emitted word leaves no partial word behind
    a_r9_empty_on_emit: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> empty);

    // R10: words only come from an open capture
    a_r10_word_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> $past(active));

    // R6: a refused start never leaves capture open
    a_r6_err_excl_active: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !active);

    // R7: once capture is closed the partial word has been flushed
    a_r7_idle_is_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> empty);

    // R1, R2: narrow widths leave the top byte zero
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && (cur_width != PW_16)) |-> (word_data[WORD_W-1:24] == '0));

    // R3: the 16-bit layout leaves bits above 19 zero
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && (cur_width == PW_16)) |-> (word_data[WORD_W-1:20] == '0));

endmodule

// File: tb/test_trace_frame_packer.sv
`timescale 1ns/1ps
module test_trace_frame_packer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_width, cfg_mode;
    logic        cap_start, cap_stop, smp_valid, smp_sync, smp_trig;
    logic [2:0]  smp_stat;
    logic [15:0] smp_pkt;
    logic        word_vld, empty, active, cfg_err;
    logic [31:0] word_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // model state
    bit          m_active = 0;
    bit          m_err    = 0;
    logic [1:0]  m_width  = 2'd0;
    logic [31:0] m_acc    = '0;
    int          m_cnt    = 0;
    bit          e_vld    = 0;
    logic [31:0] e_data   = '0;

    always #2.5 clk = ~clk;

    trace_frame_packer i_trace_frame_packer (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_mode(cfg_mode),
        .cap_start(cap_start), .cap_stop(cap_stop), .smp_valid(smp_valid),
        .smp_stat(smp_stat), .smp_pkt(smp_pkt), .smp_sync(smp_sync),
        .smp_trig(smp_trig), .word_vld(word_vld), .word_data(word_data),
        .empty(empty), .active(active), .cfg_err(cfg_err)
    );

    function automatic int spw(input logic [1:0] w);
        return (w == 2'd0) ? 3 : (w == 2'd1) ? 2 : 1;
    endfunction

    function automatic bit legal(input logic [1:0] w, input logic [1:0] md);
        return (md == 2'd0 && w != 2'd3) || (md == 2'd1 && w == 2'd1);
    endfunction

    // Slot contents and placement from R1/R2/R3/R5/R11
    function automatic logic [31:0] fmt(input logic [1:0] w, input int idx,
            input logic [2:0] st, input logic [15:0] pk, input logic sy, input logic tr);
        int pw = 4 << w;
        logic [31:0] s = '0;
        s[2:0] = tr ? 3'b110 : st;
        for (int b = 0; b < pw; b++)
            s[3+b] = (tr && b < 3) ? st[b] : pk[b];
        s[3+pw] = sy;
        return s << (idx * (pw + 4));
    endfunction

    function automatic string wtag(input logic [1:0] w);
        return (w == 2'd0) ? "R1" : (w == 2'd1) ? "R2" : "R3";
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, advance model, compare after the edge.
    task automatic step(input bit st, input bit sp, input bit v, input logic [2:0] s,
                        input logic [15:0] p, input bit sy, input bit tr, input string ctx);
        bit old;
        cap_start = st; cap_stop = sp; smp_valid = v;
        smp_stat = s; smp_pkt = p; smp_sync = sy; smp_trig = tr;
        old = m_active;
        e_vld = 0;
        if (old && v) begin
            m_acc |= fmt(m_width, m_cnt, s, p, sy, tr);
            m_cnt++;
            if (m_cnt == spw(m_width) || sp) begin
                e_vld = 1; e_data = m_acc; m_acc = '0; m_cnt = 0;
            end
        end else if (old && sp && m_cnt != 0) begin
            e_vld = 1; e_data = m_acc; m_acc = '0; m_cnt = 0;
        end
        if (old && sp) m_active = 0;
        else if (!old && st) begin
            if (legal(cfg_width, cfg_mode)) begin
                m_active = 1; m_err = 0; m_width = cfg_width;
            end else m_err = 1;
        end
        @(posedge clk);
        @(negedge clk);
        check(word_vld == e_vld, {"R4 word_vld ", ctx}, 32'(word_vld), 32'(e_vld));
        if (e_vld && word_vld)
            check(word_data == e_data, {wtag(m_width), " word_data ", ctx}, word_data, e_data);
        check(empty == (m_cnt == 0), {"R9 empty ", ctx}, 32'(empty), 32'(m_cnt == 0));
        check(active == m_active, {"R6 active ", ctx}, 32'(active), 32'(m_active));
        check(cfg_err == m_err, {"R6 cfg_err ", ctx}, 32'(cfg_err), 32'(m_err));
    endtask

    task automatic idle(input string ctx);
        step(0, 0, 0, 3'd0, 16'd0, 0, 0, ctx);
    endtask

    task automatic sample(input logic [2:0] s, input logic [15:0] p, input bit sy,
                          input bit tr, input bit sp, input string ctx);
        step(0, sp, 1, s, p, sy, tr, ctx);
    endtask

    task automatic open_cap(input logic [1:0] w, input logic [1:0] md, input string ctx);
        cfg_width = w; cfg_mode = md;
        step(1, 0, 0, 3'd0, 16'd0, 0, 0, ctx);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 0; cfg_width = 0; cfg_mode = 0;
        cap_start = 0; cap_stop = 0; smp_valid = 0;
        smp_stat = 0; smp_pkt = 0; smp_sync = 0; smp_trig = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state (R9)
        check(empty == 1'b1, "R9 empty after reset", 32'(empty), 32'd1);
        check(word_vld == 1'b0, "R4 no word after reset", 32'(word_vld), 32'd0);
        check(active == 1'b0, "R6 idle after reset", 32'(active), 32'd0);

        // R10: samples while idle are ignored
        for (int i = 0; i < 5; i++) sample(3'd5, 16'hFFFF, 1, 0, 0, "R10 idle samples");
        check(empty == 1'b1, "R10 empty stays high", 32'(empty), 32'd1);

        // R6: refused configurations
        open_cap(2'd1, 2'd2, "R6 mux refused");
        check(cfg_err == 1'b1, "R6 mux sets cfg_err", 32'(cfg_err), 32'd1);
        open_cap(2'd0, 2'd1, "R6 demux 4-bit refused");
        open_cap(2'd2, 2'd1, "R6 demux 16-bit refused");
        open_cap(2'd3, 2'd0, "R6 illegal width refused");
        open_cap(2'd1, 2'd3, "R6 reserved mode refused");
        // demux 8-bit accepted, clears cfg_err
        open_cap(2'd1, 2'd1, "R6 demux 8-bit accepted");
        check(active == 1'b1 && cfg_err == 1'b0, "R6 demux open", 32'({active, cfg_err}), 32'b10);
        // R11: upper packet bits ignored, R2 layout
        cfg_width = 2'd0; // R6: change during capture has no effect
        sample(3'd3, 16'hFF5A, 1, 0, 0, "R11 first");
        sample(3'd1, 16'hAB3C, 0, 0, 0, "R11 second");
        check(e_data == 32'h001E_1AD3 && word_data == 32'h001E_1AD3, "R2 R11 directed word",
              word_data, 32'h001E_1AD3);
        step(0, 1, 0, 3'd0, 16'd0, 0, 0, "R7 stop with empty word");
        check(word_vld == 1'b0, "R7 no word on empty stop", 32'(word_vld), 32'd0);

        // R5 directed: 4-bit trigger sample flushed alone
        open_cap(2'd0, 2'd0, "R5 open");
        sample(3'b011, 16'h000A, 1, 1, 0, "R5 trig sample");
        step(0, 1, 0, 3'd0, 16'd0, 0, 0, "R5 flush");
        check(word_data == 32'h0000_00DE, "R5 trigger slot", word_data, 32'h0000_00DE);
        check(empty == 1'b1, "R9 empty after flush", 32'(empty), 32'd1);

        // R8: stop coinciding with each slot position in every width
        for (int w = 0; w < 3; w++) begin
            for (int k = 1; k <= spw(2'(w)); k++) begin
                open_cap(2'(w), 2'd0, "R8 open");
                for (int j = 1; j <= k; j++)
                    sample(3'($urandom), 16'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0),
                           j == k, "R8 stop with sample");
                idle("R8 no extra word");
            end
        end

        // Random captures in every width, with mid-run config changes (R6)
        for (int run = 0; run < 24; run++) begin
            int w = run % 3;
            open_cap(2'(w), 2'd0, "random open");
            for (int c = 0; c < 60; c++) begin
                cfg_width = 2'($urandom);
                if ($urandom_range(0, 40) == 0) break;
                step(1'($urandom), 0, 1'($urandom_range(0, 3) != 0), 3'($urandom), 16'($urandom),
                     1'($urandom), 1'($urandom_range(0, 7) == 0), "random capture");
            end
            step(0, 1, 1'($urandom), 3'($urandom), 16'($urandom), 1'($urandom), 0, "R7 R8 random stop");
            idle("R7 after stop");
            check(empty == 1'b1, "R9 empty after stop", 32'(empty), 32'd1);
        end

        done = 1'b1;
        report();
    end

endmodule